// File: doc/BRIEF.md
# CAN Freeze and Low-Power Acknowledge Gate

This block sits beside a CAN protocol engine and decides when a request to halt the controller (freeze) or to put it to sleep (low power) may be granted. Software raises the requests. The block raises the matching acknowledge only when two conditions hold. The engine must report a protocol state in which no frame is in flight. The internal arbitration, matching, move-in and move-out units must also all be idle.

The block also watches the receive line. When that line stays dominant for a programmable number of bit times, it raises a stuck-dominant flag, and no new grant is given while the flag is set. Driver code can poll this flag to tell a blocked freeze apart from a slow one, and it can clear the block with a synchronous soft reset. The bit-stream engine, the message buffers and the register interface lie outside this block.

Top module: `can_quiesce_gate`

## Requirements
- R1: A freeze is granted only while `frz_en` and `halt_req` are both 1. With either one at 0, `frz_ack` stays 0.
- R2: `proto_state` is a one-hot vector with these bits: bit 0 idle, bit 1 intermission, bit 2 error passive, bit 3 bus off, bit 4 transmitting, bit 5 receiving. Only a one-hot value with one of bits 0 to 3 set is a safe point. Bits 4 and 5 are unsafe, and so is any value that is not one-hot, including all zeros.
- R3: While any bit of `unit_busy` is 1, no grant is given. The bits are: bit 3 arbitration, bit 2 matching, bit 1 move-in, bit 0 move-out.
- R4: An acknowledge is registered. It rises one clock after a cycle in which its request, a safe point and all-idle units coincide. Once set, it stays set for as long as its request is held, even if the state later becomes unsafe.
- R5: When the freeze request is withdrawn, `frz_ack` is 0 after the next clock edge. When `lp_req` is withdrawn, `not_ready` is 0 after the next clock edge.
- R6: `lp_req` follows the same gating rules as the freeze request and is signalled on `not_ready`. If both requests are pending, both flags may rise in the same cycle.
- R7: `stuck_dom` rises at the clock edge that counts the `stuck_limit`-th `bit_tick` during which `rx_pin` has been continuously 0 (dominant). A 1 on `rx_pin` (recessive) clears both the count and the flag at the next edge. A `stuck_limit` of 0 disables the flag.
- R8: While `stuck_dom` is 1, no acknowledge that is currently 0 can rise.
- R9: `soft_rst` clears `frz_ack`, `not_ready` and `stuck_dom` at the next edge. It takes priority over any grant in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of all flags |
| frz_en | input | 1 | Freeze enable |
| halt_req | input | 1 | Halt request |
| lp_req | input | 1 | Low-power request |
| proto_state | input | 6 | One-hot protocol state of the engine |
| unit_busy | input | 4 | Busy flags of the arbitration, matching, move-in and move-out units |
| rx_pin | input | 1 | Receive line, 0 = dominant |
| bit_tick | input | 1 | One pulse per bit time |
| stuck_limit | input | 8 | Dominant bit times before `stuck_dom` is raised |
| frz_ack | output | 1 | Freeze acknowledge |
| not_ready | output | 1 | Low-power entry acknowledge |
| stuck_dom | output | 1 | Receive line stuck dominant |

## Verification
Two pairs of functions can fall in the same cycle. First, a freeze grant and a low-power grant can be earned by the same safe idle cycle. The bench raises both requests while a busy unit holds both off, then releases the unit and expects both flags to rise together. Second, a soft reset can land in a cycle where a grant would otherwise fire. Here the bench asserts `soft_rst` together with fresh requests at a safe point and expects all flags low, then one cycle later expects the grant. A reference model built from the requirements predicts every cycle, and a scoreboard checks the result.

// File: rtl/can_quiesce_pkg.sv
package can_quiesce_pkg;

  localparam int PST_W  = 6;
  localparam int BUSY_W = 4;
  localparam int NUM_CH = 2;
  localparam int CH_FRZ = 0;
  localparam int CH_LP  = 1;

  // state bit positions
  localparam int PS_IDLE        = 0;
  localparam int PS_INTERMISSION = 1;
  localparam int PS_ERR_PASSIVE = 2;
  localparam int PS_BUS_OFF     = 3;
  localparam int PS_TRANSMIT    = 4;
  localparam int PS_RECEIVE     = 5;

  localparam logic [PST_W-1:0] SAFE_MASK =
    PST_W'((1 << PS_IDLE) | (1 << PS_INTERMISSION) |
           (1 << PS_ERR_PASSIVE) | (1 << PS_BUS_OFF));

  function automatic int unsigned ones_in(input logic [PST_W-1:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < PST_W; i++) n += 32'(v[i]);
    return n;
  endfunction

  function automatic logic state_is_safe(input logic [PST_W-1:0] v);
    return (ones_in(v) == 1) && ((v & SAFE_MASK) != '0);
  endfunction

  function automatic logic limit_hit(input int unsigned cnt, input int unsigned lim);
    return (lim != 0) && (cnt >= lim);
  endfunction

endpackage

// File: rtl/cqg_state_qualifier.sv
module cqg_state_qualifier
  import can_quiesce_pkg::*;
(
  input  logic [PST_W-1:0]  proto_state,
  input  logic [BUSY_W-1:0] unit_busy,
  input  logic              stuck_dom,
  output logic              safe_point,
  output logic              drained,
  output logic              grant_ok
);
  always_comb begin
    safe_point = state_is_safe(proto_state);
    drained    = (unit_busy == '0);
    grant_ok   = safe_point && drained && !stuck_dom;
  end
endmodule

// File: rtl/cqg_stuck_monitor.sv
module cqg_stuck_monitor #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             rx_pin,
  input  logic             bit_tick,
  input  logic [CNT_W-1:0] stuck_limit,
  output logic             stuck_dom,
  output logic             dom_bit_seen
);
  import can_quiesce_pkg::*;

  logic [CNT_W-1:0] dom_cnt;
  logic [CNT_W-1:0] dom_cnt_nxt;
  logic             rx_dominant;

  always_comb begin
    rx_dominant  = (rx_pin == 1'b0);
    dom_bit_seen = rx_dominant && bit_tick;
    if (!rx_dominant)
      dom_cnt_nxt = '0;
    else if (bit_tick && (dom_cnt < stuck_limit))
      dom_cnt_nxt = dom_cnt + 1'b1;
    else
      dom_cnt_nxt = dom_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dom_cnt   <= '0;
      stuck_dom <= 1'b0;
    end else if (soft_rst) begin
      dom_cnt   <= '0;
      stuck_dom <= 1'b0;
    end else begin
      dom_cnt   <= dom_cnt_nxt;
      stuck_dom <= rx_dominant && limit_hit(32'(dom_cnt_nxt), 32'(stuck_limit));
    end
  end
endmodule

// File: rtl/cqg_ack_channel.sv
module cqg_ack_channel (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic req,
  input  logic grant_ok,
  output logic ack
);
  logic ack_nxt;

  always_comb begin
    if (soft_rst) ack_nxt = 1'b0;
    else          ack_nxt = req && (ack || grant_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack <= 1'b0;
    else        ack <= ack_nxt;
  end
endmodule

// File: rtl/can_quiesce_gate.sv
module can_quiesce_gate
  import can_quiesce_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              frz_en,
  input  logic              halt_req,
  input  logic              lp_req,
  input  logic [PST_W-1:0]  proto_state,
  input  logic [BUSY_W-1:0] unit_busy,
  input  logic              rx_pin,
  input  logic              bit_tick,
  input  logic [CNT_W-1:0]  stuck_limit,
  output logic              frz_ack,
  output logic              not_ready,
  output logic              stuck_dom
);
  logic              safe_point;
  logic              drained;
  logic              grant_ok;
  logic              dom_bit_seen;
  logic [NUM_CH-1:0] ch_req;
  logic [NUM_CH-1:0] ch_ack;

  assign ch_req[CH_FRZ] = frz_en && halt_req;
  assign ch_req[CH_LP]  = lp_req;

  cqg_state_qualifier u_qual (
    .proto_state (proto_state),
    .unit_busy   (unit_busy),
    .stuck_dom   (stuck_dom),
    .safe_point  (safe_point),
    .drained     (drained),
    .grant_ok    (grant_ok)
  );

  cqg_stuck_monitor #(.CNT_W(CNT_W)) u_stuck (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst     (soft_rst),
    .rx_pin       (rx_pin),
    .bit_tick     (bit_tick),
    .stuck_limit  (stuck_limit),
    .stuck_dom    (stuck_dom),
    .dom_bit_seen (dom_bit_seen)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    cqg_ack_channel u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .req      (ch_req[c]),
      .grant_ok (grant_ok),
      .ack      (ch_ack[c])
    );
  end

  assign frz_ack   = ch_ack[CH_FRZ];
  assign not_ready = ch_ack[CH_LP];
endmodule

// File: rtl/cqg_checker.sv
module cqg_checker
  import can_quiesce_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic              frz_en,
  input logic              halt_req,
  input logic              lp_req,
  input logic [PST_W-1:0]  proto_state,
  input logic [BUSY_W-1:0] unit_busy,
  input logic              rx_pin,
  input logic              frz_ack,
  input logic              not_ready,
  input logic              stuck_dom
);
  assert_frz_needs_both_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frz_ack) |-> $past(frz_en && halt_req));

  assert_safe_point_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(frz_ack) || $rose(not_ready)) |-> $past(state_is_safe(proto_state)));

  assert_units_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(frz_ack) || $rose(not_ready)) |-> $past(unit_busy == '0));

  assert_frz_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(frz_en && halt_req) |=> !frz_ack);

  assert_lp_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !lp_req |=> !not_ready);

  assert_recessive_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pin |=> !stuck_dom);

  assert_stuck_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stuck_dom && !frz_ack) |=> !frz_ack);

  assert_soft_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!frz_ack && !not_ready && !stuck_dom));
endmodule

bind can_quiesce_gate cqg_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .soft_rst    (soft_rst),
  .frz_en      (frz_en),
  .halt_req    (halt_req),
  .lp_req      (lp_req),
  .proto_state (proto_state),
  .unit_busy   (unit_busy),
  .rx_pin      (rx_pin),
  .frz_ack     (frz_ack),
  .not_ready   (not_ready),
  .stuck_dom   (stuck_dom)
);

// File: tb/sim_can_quiesce_gate.sv
`timescale 1ns/1ps
module sim_can_quiesce_gate;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic       frz_en = 1'b0, halt_req = 1'b0, lp_req = 1'b0;
  logic [5:0] proto_state = 6'b000001;
  logic [3:0] unit_busy = 4'b0000;
  logic       rx_pin = 1'b1, bit_tick = 1'b0;
  logic [7:0] stuck_limit = 8'd3;
  logic       frz_ack, not_ready, stuck_dom;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  typedef struct { logic f; logic n; logic s; string tag; } exp_t;
  exp_t sb[$];

  // reference model state
  logic m_frz = 0, m_nr = 0, m_st = 0;
  int   m_cnt = 0;

  always #10 clk = ~clk;

  can_quiesce_gate u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .frz_en(frz_en),
    .halt_req(halt_req), .lp_req(lp_req), .proto_state(proto_state),
    .unit_busy(unit_busy), .rx_pin(rx_pin), .bit_tick(bit_tick),
    .stuck_limit(stuck_limit), .frz_ack(frz_ack), .not_ready(not_ready),
    .stuck_dom(stuck_dom)
  );

  task automatic chk(input logic got, input logic exp, input string tag, input string what);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %0b exp %0b at %0t", tag, what, got, exp, $time);
    end
  endtask

  // driver: inputs already set at a negedge; predict the next edge, push, advance
  task automatic step(input string tag);
    exp_t e;
    logic safe, ok;
    safe = ($countones(proto_state) == 1) && (proto_state[3:0] != 4'b0000);
    ok   = safe && (unit_busy == 4'b0000) && !m_st;
    if (soft_rst) begin
      m_frz = 0; m_nr = 0;
    end else begin
      m_frz = (frz_en && halt_req) && (m_frz || ok);
      m_nr  = lp_req && (m_nr || ok);
    end
    if (soft_rst || rx_pin) begin
      m_cnt = 0; m_st = 0;
    end else begin
      if (bit_tick && m_cnt < int'(stuck_limit)) m_cnt++;
      m_st = (stuck_limit != 0) && (m_cnt >= int'(stuck_limit));
    end
    e.f = m_frz; e.n = m_nr; e.s = m_st; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        chk(frz_ack,   e.f, e.tag, "frz_ack");
        chk(not_ready, e.n, e.tag, "not_ready");
        chk(stuck_dom, e.s, e.tag, "stuck_dom");
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(frz_ack, 1'b0, "R9", "reset frz_ack");
    chk(not_ready, 1'b0, "R9", "reset not_ready");
    chk(stuck_dom, 1'b0, "R9", "reset stuck_dom");
    rst_n = 1'b1;
    @(negedge clk);

    // R1: only one half of the freeze request
    halt_req = 1; step("R1"); step("R1");
    halt_req = 0; frz_en = 1; step("R1"); step("R1");

    // R2: unsafe protocol states
    halt_req = 1; proto_state = 6'b010000; step("R2");
    proto_state = 6'b100000; step("R2");
    proto_state = 6'b010001; step("R2");
    proto_state = 6'b000000; step("R2");

    // R3: every busy unit holds off the grant
    proto_state = 6'b000100;
    for (int b = 0; b < 4; b++) begin
      unit_busy = 4'(1 << b); step("R3");
    end
    // R6 + R4: both requests pending, same grant cycle
    lp_req = 1; unit_busy = 4'b1000; step("R6");
    unit_busy = 4'b0000; step("R6"); step("R4");
    // R4: held through unsafe state
    proto_state = 6'b100000; unit_busy = 4'b0110; step("R4"); step("R4");
    // R5: withdraw halt and low power
    halt_req = 0; step("R5");
    lp_req = 0; step("R5");

    // R9: soft reset coincides with a grant
    proto_state = 6'b001000; unit_busy = 4'b0000;
    halt_req = 1; lp_req = 1; soft_rst = 1; step("R9");
    soft_rst = 0; step("R9"); step("R9");
    soft_rst = 1; step("R9");
    soft_rst = 0; halt_req = 0; lp_req = 0; step("R5");

    // R7: stuck dominant after limit ticks
    stuck_limit = 8'd3; rx_pin = 0; bit_tick = 1;
    step("R7"); step("R7"); step("R7"); step("R7");
    bit_tick = 0; step("R7");
    // R8: stuck blocks a new grant
    proto_state = 6'b000001; halt_req = 1; lp_req = 1; step("R8"); step("R8");
    // R9: soft reset clears stuck flag, which then rebuilds
    soft_rst = 1; halt_req = 0; lp_req = 0; step("R9");
    soft_rst = 0; bit_tick = 1; step("R7"); step("R7"); step("R7");
    // R7: recessive clears
    rx_pin = 1; bit_tick = 0; step("R7");
    halt_req = 1; step("R8"); step("R8");
    halt_req = 0; step("R5");
    // R7: limit 0 disables
    stuck_limit = 8'd0; rx_pin = 0; bit_tick = 1;
    for (int i = 0; i < 6; i++) step("R7");
    // R7: interrupted dominant run restarts count
    stuck_limit = 8'd4; rx_pin = 1; step("R7");
    rx_pin = 0; step("R7"); step("R7");
    rx_pin = 1; step("R7");
    rx_pin = 0; step("R7"); step("R7"); step("R7"); step("R7"); step("R7");
    rx_pin = 1; bit_tick = 0; step("R7");

    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule